// File: doc/BRIEF.md
# Trace FIFO Flush and Idle Handshake

This block buffers trace bytes from a packet generator in a byte-wide FIFO and drains them through a ready/valid output port. A wrapper around the FIFO runs three handshakes. The first answers a flush request from the trace bus. Flush-ready rises once every byte that was queued when the request arrived has left the FIFO. The second acknowledges a processor idle request before the processor enters a wait-for-interrupt or wait-for-event state. The third forces an overflow when periodic synchronization falls behind.

A three-bit auxiliary control word holds one override bit for each handshake. Bit 0 holds flush-ready high. Bit 1 acknowledges idle requests at once. Bit 2 enables the forced overflow. The word can only be written while the trace unit is disabled. The unit counts as idle when it is disabled and its FIFO is empty.

Top module: `trace_drain_ctrl`

## Requirements
- R1: Bytes leave on `out_data` in the order they were accepted. `out_valid` is high exactly when the FIFO holds at least one byte. A byte is removed in a cycle where `out_valid` and `out_ready` are both high, and the output holds its byte while `out_ready` is low.
- R2: At full occupancy (DEPTH bytes), a push together with a pop is accepted and does not flag an overflow. A push at full occupancy without a pop is dropped and sets `ovf_flag` on the next cycle.
- R3: With flush override bit 0 clear, the rules for `flush_ready` are as follows. It is high whenever the unit is idle. While `flush_req` is held, it rises once every byte queued at the request has been output; a byte popped in the request cycle counts as output. It then stays high until `flush_req` falls. Bytes pushed after the request do not delay it.
- R4: With bit 0 of the control word set, `flush_ready` is high in every cycle, whatever the FIFO holds.
- R5: With bit 1 of the control word clear, `idle_ack` equals `idle_req` while the unit is idle (`unit_en` low and FIFO empty) and is low otherwise.
- R6: With bit 1 of the control word set, `idle_ack` equals `idle_req` whatever the FIFO holds and whatever `unit_en` is.
- R7: A synchronization becomes pending on `sync_due` and completes on `sync_done`. With bit 2 of the control word set, a `sync_due` that arrives while an earlier one is still pending, with no `sync_done` in that cycle, sets `ovf_flag` on the next cycle. With bit 2 clear, this never sets it.
- R8: `ovf_flag` is sticky and clears on the cycle after `sync_done`, unless a new overflow occurs in that same cycle. While it is set, and in the cycle a forced overflow fires, incoming bytes are dropped and the queued bytes are kept.
- R9: A write on `cfg_wr` loads `cfg_wdata` into the control word only while `unit_en` is low. It is ignored while `unit_en` is high. The current word is always visible on `aux_ctrl`.
- R10: During and right after reset, the FIFO is empty, `out_valid` and `ovf_flag` are low, and the control word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unit_en | input | 1 | Trace unit enabled |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 3 | Control word write value (bit 0 flush, bit 1 idle, bit 2 overflow force) |
| aux_ctrl | output | 3 | Current control word |
| in_valid | input | 1 | Trace byte offered |
| in_data | input | DW | Trace byte |
| out_valid | output | 1 | Drained byte available |
| out_data | output | DW | Drained byte |
| out_ready | input | 1 | Consumer takes the byte |
| flush_req | input | 1 | Flush request level from the trace bus |
| flush_ready | output | 1 | Flush complete |
| idle_req | input | 1 | Processor requests idle entry |
| idle_ack | output | 1 | Idle request acknowledged |
| sync_due | input | 1 | Synchronization due pulse |
| sync_done | input | 1 | Synchronization completed pulse |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The delicate coincidence is a flush request that arrives in the same cycle as a byte leaving the FIFO. The popped byte counts as already output, so the captured count must be one less than the occupancy. A directed case holds `out_ready` high while raising `flush_req` on a partly filled FIFO, and random stretches toggle both freely. The bench's reference model decides each cycle when `flush_ready` should rise and compares it. The same model also judges a push arriving at full occupancy together with a pop.

// File: rtl/trace_drain_pkg.sv
// Package: shared types for the trace drain controller.
// Assumes: control word is three bits; bit positions fixed as below.
package trace_drain_pkg;
    localparam int AUX_W = 3;

    // Control word: bit 2 overflow force, bit 1 idle override, bit 0 flush override.
    typedef struct packed {
        logic ovf_force;
        logic idle_force;
        logic flush_force;
    } aux_ctrl_t;
endpackage

// File: rtl/trace_byte_fifo.sv
// Module: circular byte FIFO with occupancy count.
// Assumes: caller may push and pop in the same cycle at full occupancy;
// pushes when full without a pop and pops when empty are ignored.
module trace_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] occ,
    output logic          empty,
    output logic          full
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_push;
    logic          do_pop;

    // Advance a pointer with wrap at DEPTH-1 (DEPTH need not be a power of two).
    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // Qualify requests against current occupancy.
    always_comb begin
        empty   = (occ == '0);
        full    = (occ == CW'(DEPTH));
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   occ <= occ + CW'(1);
                2'b01:   occ <= occ - CW'(1);
                default: occ <= occ;
            endcase
        end
    end

    // Head of queue is presented combinationally.
    assign head_data = mem[rd_ptr];
endmodule

// File: rtl/flush_tracker.sv
// Module: tracks bytes queued ahead of a flush request.
// Assumes: flush_req is a level held until ready is seen; pop is a real
// output transfer; occ is the FIFO occupancy in the request cycle.
module flush_tracker #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_req,
    input  logic          pop,
    input  logic [CW-1:0] occ,
    input  logic          idle,
    input  logic          force_ready,
    output logic          flush_ready
);
    logic          tracking;
    logic [CW-1:0] remain;

    // Capture the backlog at request start, then count it down on each pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tracking <= 1'b0;
            remain   <= '0;
        end else if (!flush_req) begin
            tracking <= 1'b0;
            remain   <= '0;
        end else if (!tracking) begin
            tracking <= 1'b1;
            remain   <= occ - CW'(pop);
        end else if (pop && (remain != '0)) begin
            remain <= remain - CW'(1);
        end
    end

    // Ready when overridden, idle, or the captured backlog has drained.
    assign flush_ready = force_ready || idle || (tracking && (remain == '0));
endmodule

// File: rtl/sync_ovf_guard.sv
// Module: pending-sync tracking and sticky overflow flag.
// Assumes: sync_due and sync_done are single-cycle pulses; overrun flags a
// push that found the FIFO full with no pop in the same cycle.
module sync_ovf_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_due,
    input  logic sync_done,
    input  logic force_en,
    input  logic overrun,
    output logic force_evt,
    output logic ovf_flag
);
    logic pending;

    // A new due while the previous sync is still open is a late sync.
    assign force_evt = force_en && sync_due && pending && !sync_done;

    // Pending sync: completion closes the old one, a due opens a new one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else begin
            pending <= sync_due || (pending && !sync_done);
        end
    end

    // Sticky overflow: set beats clear, completion clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (force_evt || overrun) begin
            ovf_flag <= 1'b1;
        end else if (sync_done) begin
            ovf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/aux_ctrl_reg.sv
// Module: three-bit override control word.
// Assumes: writes are only legal while the trace unit is disabled.
module aux_ctrl_reg
    import trace_drain_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [AUX_W-1:0] cfg_wdata,
    input  logic             unit_en,
    output aux_ctrl_t        ctrl
);
    // Load on write only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (cfg_wr && !unit_en) begin
            ctrl <= aux_ctrl_t'(cfg_wdata);
        end
    end
endmodule

// File: rtl/trace_drain_ctrl.sv
// Module: trace FIFO with flush, idle and overflow handshakes (top).
// Assumes: single clock, synchronous active-low reset; input bytes have no
// back-pressure and are dropped when they cannot be stored.
module trace_drain_ctrl
    import trace_drain_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             unit_en,
    input  logic             cfg_wr,
    input  logic [AUX_W-1:0] cfg_wdata,
    output logic [AUX_W-1:0] aux_ctrl,
    input  logic             in_valid,
    input  logic [DW-1:0]    in_data,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    input  logic             out_ready,
    input  logic             flush_req,
    output logic             flush_ready,
    input  logic             idle_req,
    output logic             idle_ack,
    input  logic             sync_due,
    input  logic             sync_done,
    output logic             ovf_flag
);
    localparam int CW = $clog2(DEPTH + 1);

    aux_ctrl_t     ctrl;
    logic [CW-1:0] fifo_occ;
    logic          fifo_empty;
    logic          fifo_full;
    logic          pop;
    logic          push;
    logic          overrun;
    logic          force_evt;
    logic          unit_idle;

    // Handshake and gating terms shared by the sub-blocks.
    always_comb begin
        pop       = out_ready && !fifo_empty;
        overrun   = in_valid && !ovf_flag && fifo_full && !pop;
        push      = in_valid && !ovf_flag && !force_evt && (!fifo_full || pop);
        unit_idle = !unit_en && fifo_empty;
        idle_ack  = idle_req && (ctrl.idle_force || unit_idle);
        out_valid = !fifo_empty;
        aux_ctrl  = ctrl;
    end

    aux_ctrl_reg u_aux (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .unit_en   (unit_en),
        .ctrl      (ctrl)
    );

    trace_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (in_data),
        .pop       (pop),
        .head_data (out_data),
        .occ       (fifo_occ),
        .empty     (fifo_empty),
        .full      (fifo_full)
    );

    flush_tracker #(.CW(CW)) u_flush (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_req   (flush_req),
        .pop         (pop),
        .occ         (fifo_occ),
        .idle        (unit_idle),
        .force_ready (ctrl.flush_force),
        .flush_ready (flush_ready)
    );

    sync_ovf_guard u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_due  (sync_due),
        .sync_done (sync_done),
        .force_en  (ctrl.ovf_force),
        .overrun   (overrun),
        .force_evt (force_evt),
        .ovf_flag  (ovf_flag)
    );
endmodule

// File: rtl/trace_drain_chk.sv
// Module: protocol checks for trace_drain_ctrl, attached by bind.
// Assumes: synchronous active-low reset; occ is the FIFO occupancy.
module trace_drain_chk #(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          unit_en,
    input logic [2:0]    aux_ctrl,
    input logic          in_valid,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          flush_ready,
    input logic          idle_req,
    input logic          idle_ack,
    input logic          sync_done,
    input logic          ovf_flag,
    input logic [CW-1:0] occ
);
    // R1
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R4
    flush_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_ctrl[0] |-> flush_ready);
    // R5
    idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_ctrl[1] && idle_ack |-> idle_req && !unit_en && !out_valid);
    // R6
    idle_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_ctrl[1] && idle_req |-> idle_ack);
    // R7
    force_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_ctrl[2] && !ovf_flag && !in_valid |=> !ovf_flag);
    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !sync_done |=> ovf_flag);
    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done && !in_valid |=> !ovf_flag);
    // R8
    drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !(out_valid && out_ready) |=> occ == $past(occ));
    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unit_en |=> $stable(aux_ctrl));
endmodule

bind trace_drain_ctrl trace_drain_chk #(.DW(DW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .unit_en     (unit_en),
    .aux_ctrl    (aux_ctrl),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .flush_ready (flush_ready),
    .idle_req    (idle_req),
    .idle_ack    (idle_ack),
    .sync_done   (sync_done),
    .ovf_flag    (ovf_flag),
    .occ         (fifo_occ)
);

// File: tb/trace_drain_ctrl_tb.sv
// Bench: reference model of queue, flush, idle and overflow rules,
// directed corner cases followed by seeded random traffic.
module trace_drain_ctrl_tb;
    localparam int DEPTH = 16;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          unit_en = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_wdata = '0;
    logic [2:0]    aux_ctrl;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          out_valid;
    logic [DW-1:0] out_data;
    logic          out_ready = 1'b0;
    logic          flush_req = 1'b0;
    logic          flush_ready;
    logic          idle_req = 1'b0;
    logic          idle_ack;
    logic          sync_due = 1'b0;
    logic          sync_done = 1'b0;
    logic          ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Reference model state.
    logic [DW-1:0] m_q[$];
    bit            m_ovf = 0;
    bit            m_pend = 0;
    logic [2:0]    m_aux = '0;
    bit            m_fact = 0;
    int            m_fcnt = 0;

    always #4 clk = ~clk;

    trace_drain_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .unit_en(unit_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .aux_ctrl(aux_ctrl), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .flush_req(flush_req), .flush_ready(flush_ready),
        .idle_req(idle_req), .idle_ack(idle_ack), .sync_due(sync_due),
        .sync_done(sync_done), .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_idle();
        return !unit_en && (m_q.size() == 0);
    endfunction

    function automatic bit exp_flush_ready();
        return m_aux[0] || exp_idle() || (m_fact && m_fcnt == 0);
    endfunction

    function automatic bit exp_idle_ack();
        return idle_req && (m_aux[1] || exp_idle());
    endfunction

    // Compare outputs against the model, advance the model, wait a cycle.
    task automatic step();
        bit pop, force_evt, full, push, overrun;
        #1;
        check("R1 out_valid", int'(out_valid), int'(m_q.size() > 0));
        if (m_q.size() > 0) check("R1 out_data", int'(out_data), int'(m_q[0]));
        check(m_aux[0] ? "R4 flush_ready" : "R3 flush_ready",
              int'(flush_ready), int'(exp_flush_ready()));
        check(m_aux[1] ? "R6 idle_ack" : "R5 idle_ack",
              int'(idle_ack), int'(exp_idle_ack()));
        check("R8 ovf_flag", int'(ovf_flag), int'(m_ovf));
        check("R9 aux_ctrl", int'(aux_ctrl), int'(m_aux));
        pop       = out_ready && (m_q.size() > 0);
        force_evt = m_aux[2] && sync_due && m_pend && !sync_done;
        full      = (m_q.size() == DEPTH);
        overrun   = in_valid && !m_ovf && full && !pop;
        push      = in_valid && !m_ovf && !force_evt && (!full || pop);
        if (!flush_req) begin
            m_fact = 0;
            m_fcnt = 0;
        end else if (!m_fact) begin
            m_fact = 1;
            m_fcnt = m_q.size() - int'(pop);
        end else if (pop && m_fcnt > 0) begin
            m_fcnt--;
        end
        if (pop) void'(m_q.pop_front());
        if (push) m_q.push_back(in_data);
        if (force_evt || overrun) m_ovf = 1;
        else if (sync_done) m_ovf = 0;
        m_pend = sync_due || (m_pend && !sync_done);
        if (cfg_wr && !unit_en) m_aux = cfg_wdata;
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cfg_wr = 0; in_valid = 0; out_ready = 0; sync_due = 0; sync_done = 0;
    endtask

    task automatic write_aux(input logic [2:0] v);
        unit_en = 0; cfg_wr = 1; cfg_wdata = v; step(); cfg_wr = 0;
    endtask

    initial begin
        void'($urandom(32'h1d0c_5eed));
        repeat (3) @(negedge clk);
        // R10: reset state while reset held.
        #1;
        check("R10 out_valid in reset", int'(out_valid), 0);
        check("R10 ovf_flag in reset", int'(ovf_flag), 0);
        check("R10 aux_ctrl in reset", int'(aux_ctrl), 0);
        @(negedge clk);
        rst_n = 1;
        step();
        check("R10 out_valid after reset", int'(out_valid), 0);

        // R9: write ignored while enabled, accepted while disabled.
        unit_en = 1; cfg_wr = 1; cfg_wdata = 3'b111; step();
        check("R9 write ignored when enabled", int'(aux_ctrl), 0);
        write_aux(3'b000);

        // R2: fill to full, then push+pop at full, then overrun.
        unit_en = 1; idle_inputs();
        for (int i = 0; i < DEPTH; i++) begin
            in_valid = 1; in_data = DW'(8'h40 + i); step();
        end
        in_valid = 1; out_ready = 1; in_data = 8'hA5; step();
        check("R2 push with pop at full keeps ovf low", int'(ovf_flag), 0);
        out_ready = 0; in_data = 8'h5A; step();
        check("R2 push at full without pop sets ovf", int'(ovf_flag), 1);
        in_valid = 1; in_data = 8'h77; step();
        check("R8 dropped while ovf, still full", int'(out_valid), 1);
        in_valid = 0; sync_done = 1; step(); sync_done = 0;
        check("R8 ovf cleared by sync_done", int'(ovf_flag), 0);

        // R3: flush request arriving with a pop in the same cycle.
        for (int i = 0; i < DEPTH - 6; i++) begin
            out_ready = 1; step();
        end
        flush_req = 1; out_ready = 1; in_valid = 1; in_data = 8'h11; step();
        for (int i = 0; i < 8; i++) begin
            out_ready = 1; in_valid = 1; in_data = DW'(i); step();
        end
        check("R3 flush_ready after backlog drained", int'(flush_ready), 1);
        flush_req = 0; in_valid = 0; step();
        check("R3 flush_ready drops with request", int'(flush_ready), 0);

        // R7: late sync forces overflow only with bit 2 set.
        idle_inputs();
        sync_due = 1; step(); sync_due = 1; step(); sync_due = 0; step();
        check("R7 no force with bit 2 clear", int'(ovf_flag), 0);
        sync_done = 1; step(); sync_done = 0;
        write_aux(3'b100);
        unit_en = 1;
        sync_due = 1; step(); sync_due = 1; step(); sync_due = 0;
        check("R7 forced overflow on late sync", int'(ovf_flag), 1);
        sync_done = 1; step(); sync_done = 0;

        // R5/R6: idle acknowledge with and without override.
        write_aux(3'b000);
        unit_en = 1; in_valid = 1; in_data = 8'hC3; step(); in_valid = 0;
        idle_req = 1; unit_en = 0; step();
        check("R5 no ack while bytes queued", int'(idle_ack), 0);
        write_aux(3'b010);
        idle_req = 1; step();
        check("R6 ack despite queued byte", int'(idle_ack), 1);
        write_aux(3'b001);
        unit_en = 1; step();
        check("R4 flush_ready forced", int'(flush_ready), 1);
        out_ready = 1; step(); step();
        idle_req = 0;
        write_aux(3'b000);

        // Random traffic.
        begin
            int en_bias = 1;
            int rdy_bias = 2;
            for (int cyc = 0; cyc < 6000; cyc++) begin
                if (cyc % 150 == 0) begin
                    en_bias  = int'($urandom % 4);
                    rdy_bias = int'($urandom % 5);
                end
                unit_en   = (en_bias != 0);
                cfg_wr    = ($urandom % 20) == 0;
                cfg_wdata = 3'($urandom);
                in_valid  = unit_en && (($urandom % 4) != 0);
                in_data   = DW'($urandom);
                out_ready = int'($urandom % 4) < rdy_bias;
                if (($urandom % 20) == 0) flush_req = !flush_req;
                idle_req  = ($urandom % 3) == 0;
                sync_due  = ($urandom % 25) == 0;
                sync_done = ($urandom % 30) == 0;
                step();
            end
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule